// File: doc/BRIEF.md
# Descriptor Ring Sequencer

This block walks two circular lists of buffer descriptors, one for transmit and one for receive, kept in a small flop-based descriptor store inside the block. Each descriptor is a 16-bit status word, a 16-bit length and a 32-bit buffer pointer. Software fills descriptors through a host port, then pulses a per-ring task enable. The receive walker writes each finished frame's length and outcome into the next empty descriptor. The transmit walker takes each ready descriptor, presents its length, pointer and flags to a frame source, and returns the descriptor to software once the frame source reports it sent.

A ring closes at the descriptor that carries the wrap flag, or at the last slot of the store. A walker that meets a descriptor software has not handed over stops, and stays stopped until its task enable is pulsed again. It then resumes at the same index. Each completed descriptor raises a one-cycle done pulse and sets a sticky event bit that is cleared by writing 1.

Top module: `desc_ring_seq`

## Requirements
- R1: After a synchronous active-low reset, every descriptor reads as zero, both walkers are stopped at index 0, `rx_ready`, `tx_req`, both done pulses and `evt` are 0.
- R2: `rx_ready` is high exactly when the receive walker is running and its current descriptor has the empty flag (status bit 15) set. A frame is accepted only on a cycle with `rx_frame_valid` and `rx_ready` both high.
- R3: An accepted frame rewrites the current receive descriptor. The status keeps only the wrap flag (bit 13), and sets the last flag (bit 11) and the error flag (bit 0) equal to `rx_frame_err`; this clears the empty flag. The length becomes `rx_frame_len`, which includes the 4-byte frame check sequence. The pointer is unchanged.
- R4: After a write-back the ring index moves to 0 if the descriptor had the wrap flag or was at slot DEPTH-1, and to index+1 otherwise.
- R5: A running receive walker whose current descriptor is not empty stops. Frames offered while it is stopped change no descriptor. A later `rx_task_en` pulse resumes it at the same index.
- R6: A running transmit walker that is idle and whose current descriptor has the ready flag (bit 15) set starts that descriptor. From the next cycle `tx_req` is high, with `tx_len` and `tx_ptr` from the descriptor, `tx_crc` from bit 10 and `tx_last` from bit 11. These stay stable while `tx_req` is high.
- R7: `tx_sent` while `tx_req` is high writes the descriptor back with only the ready flag cleared and drops `tx_req` on the next cycle. `tx_sent` while `tx_req` is low has no effect.
- R8: A running, idle transmit walker whose current descriptor is not ready stops. Setting that descriptor ready afterwards does not start it until `tx_task_en` is pulsed.
- R9: `rx_done` or `tx_done` is high for exactly the one cycle that follows the clock edge of that ring's write-back.
- R10: `evt[1]` (receive) and `evt[0]` (transmit) are set at the edge of each write-back and cleared by a 1 on the matching `evt_clr` bit. A set in the same cycle wins over a clear.
- R11: A stop input halts its walker from the next cycle, taking priority over a task enable in the same cycle. A transmit frame already started still completes and is written back, and no further descriptor starts.
- R12: A host write stores the descriptor at `host_sel` (0 transmit, 1 receive) and `host_idx`. The read outputs return the addressed descriptor one cycle after the address is presented. When a host write and a walker write-back hit the same descriptor in one cycle, the write-back wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host descriptor write strobe |
| host_sel | input | 1 | Ring select, 0 transmit, 1 receive |
| host_idx | input | IDX_W | Descriptor index for host read and write |
| host_wstatus | input | 16 | Status word to write |
| host_wlen | input | 16 | Length to write |
| host_wptr | input | 32 | Buffer pointer to write |
| host_rstatus | output | 16 | Status word read back |
| host_rlen | output | 16 | Length read back |
| host_rptr | output | 32 | Pointer read back |
| rx_task_en | input | 1 | Start or resume the receive walk |
| rx_stop | input | 1 | Halt the receive walk |
| rx_frame_valid | input | 1 | A received frame has ended this cycle |
| rx_frame_len | input | 16 | Byte count of that frame including FCS |
| rx_frame_err | input | 1 | That frame was bad |
| rx_ready | output | 1 | An empty descriptor is available |
| rx_done | output | 1 | Receive descriptor completed pulse |
| tx_task_en | input | 1 | Start or resume the transmit walk |
| tx_stop | input | 1 | Halt the transmit walk |
| tx_req | output | 1 | A frame is handed to the frame source |
| tx_len | output | 16 | Frame length |
| tx_ptr | output | 32 | Frame buffer pointer |
| tx_crc | output | 1 | Append frame check sequence |
| tx_last | output | 1 | Descriptor ends the frame |
| tx_sent | input | 1 | The frame source has finished the frame |
| tx_done | output | 1 | Transmit descriptor completed pulse |
| evt | output | 2 | Sticky events, bit 1 receive, bit 0 transmit |
| evt_clr | input | 2 | Write-1-to-clear for `evt` |

## Verification
`rx_ready` follows the walker state and store contents within the same cycle. `rx_done`, `tx_done`, `evt` and the host read data are due one rising edge after the stimulus that causes them. `tx_req` rises two edges after a task enable pulse (one to start running, one to latch the descriptor) and falls one edge after `tx_sent`. The bench drives inputs just after each rising edge, steps a behavioural model on the same rising edge, and compares every output at the following falling edge. Directed checks are placed at the falling edge that follows the counted number of rising edges.

// File: rtl/ring_seq_pkg.sv
// Shared descriptor layout and status flag positions for the ring sequencer.
// Assumes a 16-bit status word, a 16-bit length and a 32-bit pointer.
package ring_seq_pkg;
    localparam int ST_W      = 16;
    localparam int LEN_W     = 16;
    localparam int PTR_W     = 32;
    localparam int BIT_OWN   = 15;  // empty (receive) / ready (transmit)
    localparam int BIT_WRAP  = 13;
    localparam int BIT_LAST  = 11;
    localparam int BIT_TXCRC = 10;
    localparam int BIT_ERR   = 0;

    typedef struct packed {
        logic [ST_W-1:0]  status;
        logic [LEN_W-1:0] len;
        logic [PTR_W-1:0] ptr;
    } desc_t;
endpackage

// File: rtl/ring_desc_mem.sv
// Flop-based descriptor store for one ring. It has a host port with a
// registered read and a write, and a walker port with a combinational read
// and a write. Assumes that on a same-index collision the walker write wins.
module ring_desc_mem
    import ring_seq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  desc_t            host_wdesc,
    output desc_t            host_rdesc,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_idx,
    input  desc_t            eng_wdesc,
    output desc_t            eng_rdesc
);
    desc_t mem [DEPTH];

    // Walker sees the current descriptor without delay.
    assign eng_rdesc = mem[eng_idx];

    // Host read register and both writes; the later walker write wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdesc <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            host_rdesc <= mem[host_idx];
            if (host_we) mem[host_idx] <= host_wdesc;
            if (eng_we)  mem[eng_idx]  <= eng_wdesc;
        end
    end
endmodule

// File: rtl/rx_ring_walker.sv
// Receive walker. It offers the current descriptor while that descriptor is
// empty, and writes an accepted frame's length and outcome into it. It stops
// on a non-empty descriptor. Assumes a frame ends in one cycle.
module rx_ring_walker
    import ring_seq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             task_en,
    input  logic             stop,
    input  logic             frame_valid,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             frame_err,
    input  desc_t            cur,
    output logic [IDX_W-1:0] idx,
    output logic             wb_we,
    output desc_t            wb_desc,
    output logic             ready,
    output logic             done
);
    logic run;

    // Next slot: wrap flag or the physical end closes the ring.
    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i, input logic w);
        if (w || i == IDX_W'(DEPTH - 1)) return '0;
        return i + 1'b1;
    endfunction

    assign ready = run && cur.status[BIT_OWN];
    assign wb_we = frame_valid && ready;

    // Build the completed descriptor: keep wrap and pointer, mark last/error.
    always_comb begin
        wb_desc        = cur;
        wb_desc.status = '0;
        wb_desc.status[BIT_WRAP] = cur.status[BIT_WRAP];
        wb_desc.status[BIT_LAST] = 1'b1;
        wb_desc.status[BIT_ERR]  = frame_err;
        wb_desc.len    = frame_len;
    end

    // Run flag, ring index and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            idx  <= '0;
            done <= 1'b0;
        end else begin
            done <= wb_we;
            if (wb_we) idx <= step(idx, cur.status[BIT_WRAP]);
            if (stop)                                run <= 1'b0;
            else if (task_en)                        run <= 1'b1;
            else if (run && !cur.status[BIT_OWN])    run <= 1'b0;
        end
    end

    assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wb_we) |-> (idx == '0 || idx == IDX_W'($past(idx) + 1'b1)));
    assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cur.status[BIT_OWN] && !task_en) |=> !ready);
endmodule

// File: rtl/tx_ring_walker.sv
// Transmit walker. It latches the next ready descriptor, presents it to the
// frame source until that source reports the frame sent, then writes the
// descriptor back with ready cleared. Stops on a descriptor that is not
// ready. Assumes software leaves a started descriptor alone.
module tx_ring_walker
    import ring_seq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             task_en,
    input  logic             stop,
    input  logic             sent,
    input  desc_t            cur,
    output logic [IDX_W-1:0] idx,
    output logic             wb_we,
    output desc_t            wb_desc,
    output logic             req,
    output logic [LEN_W-1:0] len,
    output logic [PTR_W-1:0] ptr,
    output logic             crc,
    output logic             last,
    output logic             done
);
    logic  run, busy;
    desc_t held;

    // Next slot: wrap flag or the physical end closes the ring.
    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i, input logic w);
        if (w || i == IDX_W'(DEPTH - 1)) return '0;
        return i + 1'b1;
    endfunction

    assign req   = busy;
    assign len   = held.len;
    assign ptr   = held.ptr;
    assign crc   = held.status[BIT_TXCRC];
    assign last  = held.status[BIT_LAST];
    assign wb_we = busy && sent;

    // Return the held descriptor to software with only ready cleared.
    always_comb begin
        wb_desc = held;
        wb_desc.status[BIT_OWN] = 1'b0;
    end

    // Start, completion, ring index, run flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            busy <= 1'b0;
            held <= '0;
            idx  <= '0;
            done <= 1'b0;
        end else begin
            done <= wb_we;
            if (wb_we) begin
                busy <= 1'b0;
                idx  <= step(idx, held.status[BIT_WRAP]);
            end else if (!busy && run && cur.status[BIT_OWN]) begin
                busy <= 1'b1;
                held <= cur;
            end
            if (stop)                                      run <= 1'b0;
            else if (task_en)                              run <= 1'b1;
            else if (run && !busy && !cur.status[BIT_OWN]) run <= 1'b0;
        end
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $past(req)) |-> ($stable(len) && $stable(ptr) && $stable(crc)));
    assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(sent));
endmodule

// File: rtl/desc_ring_seq.sv
// Descriptor ring sequencer top. It has one descriptor store and one walker
// per ring, a shared host port and sticky completion events. Assumes
// DEPTH >= 2 and that host_sel is 0 for transmit and 1 for receive.
module desc_ring_seq
    import ring_seq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic             host_sel,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [15:0]      host_wstatus,
    input  logic [15:0]      host_wlen,
    input  logic [31:0]      host_wptr,
    output logic [15:0]      host_rstatus,
    output logic [15:0]      host_rlen,
    output logic [31:0]      host_rptr,
    input  logic             rx_task_en,
    input  logic             rx_stop,
    input  logic             rx_frame_valid,
    input  logic [15:0]      rx_frame_len,
    input  logic             rx_frame_err,
    output logic             rx_ready,
    output logic             rx_done,
    input  logic             tx_task_en,
    input  logic             tx_stop,
    output logic             tx_req,
    output logic [15:0]      tx_len,
    output logic [31:0]      tx_ptr,
    output logic             tx_crc,
    output logic             tx_last,
    input  logic             tx_sent,
    output logic             tx_done,
    output logic [1:0]       evt,
    input  logic [1:0]       evt_clr
);
    desc_t            host_wdesc, tx_cur, rx_cur, tx_wb, rx_wb, tx_hr, rx_hr, host_r;
    logic             tx_we, rx_we, sel_q;
    logic [IDX_W-1:0] tx_idx, rx_idx;

    assign host_wdesc = '{status: host_wstatus, len: host_wlen, ptr: host_wptr};

    ring_desc_mem #(.DEPTH(DEPTH)) u_tx_mem (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we && !host_sel), .host_idx(host_idx),
        .host_wdesc(host_wdesc), .host_rdesc(tx_hr),
        .eng_we(tx_we), .eng_idx(tx_idx), .eng_wdesc(tx_wb), .eng_rdesc(tx_cur)
    );

    ring_desc_mem #(.DEPTH(DEPTH)) u_rx_mem (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we && host_sel), .host_idx(host_idx),
        .host_wdesc(host_wdesc), .host_rdesc(rx_hr),
        .eng_we(rx_we), .eng_idx(rx_idx), .eng_wdesc(rx_wb), .eng_rdesc(rx_cur)
    );

    rx_ring_walker #(.DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n), .task_en(rx_task_en), .stop(rx_stop),
        .frame_valid(rx_frame_valid), .frame_len(rx_frame_len),
        .frame_err(rx_frame_err), .cur(rx_cur), .idx(rx_idx),
        .wb_we(rx_we), .wb_desc(rx_wb), .ready(rx_ready), .done(rx_done)
    );

    tx_ring_walker #(.DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n), .task_en(tx_task_en), .stop(tx_stop),
        .sent(tx_sent), .cur(tx_cur), .idx(tx_idx), .wb_we(tx_we),
        .wb_desc(tx_wb), .req(tx_req), .len(tx_len), .ptr(tx_ptr),
        .crc(tx_crc), .last(tx_last), .done(tx_done)
    );

    // Remember which ring the registered host read came from.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= host_sel;
    end

    assign host_r       = sel_q ? rx_hr : tx_hr;
    assign host_rstatus = host_r.status;
    assign host_rlen    = host_r.len;
    assign host_rptr    = host_r.ptr;

    // Sticky completion events; a new completion beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= '0;
        else        evt <= (evt & ~evt_clr) | {rx_we, tx_we};
    end

    assert_rx_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(rx_frame_valid && rx_ready));
    assert_tx_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(tx_req && tx_sent));
    assert_evt_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> evt[1]);
    assert_evt_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> evt[0]);
endmodule

// File: tb/sim_desc_ring_seq.sv
// Bench: a behavioural model is stepped on each rising edge and compared at
// each falling edge, with directed checks on the corner cases in between.
module sim_desc_ring_seq;
    localparam int D = 8;
    localparam int IW = $clog2(D);

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_we = 0, host_sel = 0;
    logic [IW-1:0] host_idx = '0;
    logic [15:0] host_wstatus = 0, host_wlen = 0;
    logic [31:0] host_wptr = 0;
    logic [15:0] host_rstatus, host_rlen;
    logic [31:0] host_rptr;
    logic rx_task_en = 0, rx_stop = 0, rx_frame_valid = 0, rx_frame_err = 0;
    logic [15:0] rx_frame_len = 0;
    logic rx_ready, rx_done;
    logic tx_task_en = 0, tx_stop = 0, tx_sent = 0;
    logic tx_req, tx_crc, tx_last, tx_done;
    logic [15:0] tx_len;
    logic [31:0] tx_ptr;
    logic [1:0] evt, evt_clr = 2'b00;

    int vectors = 0, miscompares = 0;

    always #2.5 clk = ~clk;

    desc_ring_seq #(.DEPTH(D)) u0 (.*);

    // Behavioural model state.
    logic [15:0] ms [2][D];
    logic [15:0] ml [2][D];
    logic [31:0] mp [2][D];
    int m_ri, m_ti;
    bit m_rrun, m_trun, m_busy, m_rdone, m_tdone;
    logic [15:0] m_ls, m_ll, m_rst, m_rln;
    logic [31:0] m_lp, m_rpt;
    logic [1:0] m_evt;

    // Model step on each rising edge.
    always @(posedge clk) begin
        logic [15:0] rc, tc;
        bit rwb, twb, tstart, busy0;
        if (!rst_n) begin
            for (int r = 0; r < 2; r++)
                for (int i = 0; i < D; i++) begin ms[r][i] = 0; ml[r][i] = 0; mp[r][i] = 0; end
            m_ri = 0; m_ti = 0; m_rrun = 0; m_trun = 0; m_busy = 0;
            m_rdone = 0; m_tdone = 0; m_ls = 0; m_ll = 0; m_lp = 0;
            m_rst = 0; m_rln = 0; m_rpt = 0; m_evt = 0;
        end else begin
            rc = ms[1][m_ri]; tc = ms[0][m_ti]; busy0 = m_busy;
            rwb = rx_frame_valid && m_rrun && rc[15];
            twb = m_busy && tx_sent;
            tstart = !m_busy && m_trun && tc[15];
            m_rst = ms[host_sel][host_idx]; m_rln = ml[host_sel][host_idx]; m_rpt = mp[host_sel][host_idx];
            if (host_we) begin
                ms[host_sel][host_idx] = host_wstatus;
                ml[host_sel][host_idx] = host_wlen;
                mp[host_sel][host_idx] = host_wptr;
            end
            if (rwb) begin
                ms[1][m_ri] = (rc & 16'h2000) | 16'h0800 | {15'b0, rx_frame_err};
                ml[1][m_ri] = rx_frame_len;
                m_ri = (rc[13] || m_ri == D - 1) ? 0 : m_ri + 1;
            end
            if (twb) begin
                ms[0][m_ti] = m_ls & 16'h7fff; ml[0][m_ti] = m_ll; mp[0][m_ti] = m_lp;
                m_ti = (m_ls[13] || m_ti == D - 1) ? 0 : m_ti + 1;
                m_busy = 0;
            end else if (tstart) begin
                m_busy = 1; m_ls = tc; m_ll = ml[0][m_ti]; m_lp = mp[0][m_ti];
            end
            m_rdone = rwb; m_tdone = twb;
            m_evt = (m_evt & ~evt_clr) | {rwb, twb};
            if (rx_stop) m_rrun = 0; else if (rx_task_en) m_rrun = 1; else if (m_rrun && !rc[15]) m_rrun = 0;
            if (tx_stop) m_trun = 0; else if (tx_task_en) m_trun = 1;
            else if (m_trun && !busy0 && !tc[15]) m_trun = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Full comparison against the model at every falling edge.
    always @(negedge clk) if (rst_n) begin
        chk("R2 rx_ready", 32'(rx_ready), 32'(m_rrun && ms[1][m_ri][15]));
        chk("R9 rx_done", 32'(rx_done), 32'(m_rdone));
        chk("R9 tx_done", 32'(tx_done), 32'(m_tdone));
        chk("R7 tx_req", 32'(tx_req), 32'(m_busy));
        chk("R6 tx_len", 32'(tx_len), 32'(m_ll));
        chk("R6 tx_ptr", tx_ptr, m_lp);
        chk("R6 tx_crc/last", {30'b0, tx_crc, tx_last}, {30'b0, m_ls[10], m_ls[11]});
        chk("R10 evt", 32'(evt), 32'(m_evt));
        chk("R12 host read", {host_rstatus, host_rlen}, {m_rst, m_rln});
        chk("R12 host ptr", host_rptr, m_rpt);
    end

    task automatic cyc(); @(posedge clk); #1; endtask
    task automatic hw(input bit s, input int i, input logic [15:0] st, input logic [15:0] ln, input logic [31:0] pt);
        host_we = 1; host_sel = s; host_idx = IW'(i); host_wstatus = st; host_wlen = ln; host_wptr = pt;
        cyc(); host_we = 0;
    endtask
    task automatic hr(input bit s, input int i);
        host_sel = s; host_idx = IW'(i); cyc(); @(negedge clk);
    endtask
    task automatic rxf(input logic [15:0] ln, input bit e);
        rx_frame_valid = 1; rx_frame_len = ln; rx_frame_err = e; cyc(); rx_frame_valid = 0; rx_frame_err = 0;
    endtask

    initial begin
        #100000;
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rx_ready", 32'(rx_ready), 0); chk("R1 tx_req", 32'(tx_req), 0);
        chk("R1 evt", 32'(evt), 0); chk("R1 read", 32'(host_rstatus), 0);

        // Receive ring of two, closed by wrap on slot 1.
        hw(1, 0, 16'h8000, 0, 32'h1000);
        hw(1, 1, 16'hA000, 0, 32'h1100);
        rx_task_en = 1; cyc(); rx_task_en = 0;
        @(negedge clk); chk("R2 ready when empty", 32'(rx_ready), 1);
        rxf(64, 0);
        @(negedge clk); chk("R9 rx_done pulse", 32'(rx_done), 1); chk("R10 rx evt", 32'(evt[1]), 1);
        rxf(100, 1);
        cyc(); cyc();
        @(negedge clk); chk("R5 stalled", 32'(rx_ready), 0);
        rxf(77, 0);
        hr(1, 1);
        chk("R3 status", 32'(host_rstatus), 32'h2801); chk("R3 len", 32'(host_rlen), 100);
        chk("R3 ptr", host_rptr, 32'h1100);
        hr(1, 0);
        chk("R3 status ok", 32'(host_rstatus), 32'h0800); chk("R5 ignored frame", 32'(host_rlen), 64);
        hw(1, 0, 16'h8000, 0, 32'h1000);
        cyc(); @(negedge clk); chk("R5 no self restart", 32'(rx_ready), 0);
        rx_task_en = 1; cyc(); rx_task_en = 0;
        @(negedge clk); chk("R5 resumed", 32'(rx_ready), 1);
        rxf(90, 0);
        hr(1, 0); chk("R4 wrapped to slot 0", 32'(host_rlen), 90);

        // Transmit ring.
        hw(0, 0, 16'h8C00, 60, 32'h2000);
        hw(0, 1, 16'h8000, 70, 32'h2100);
        tx_task_en = 1; cyc(); tx_task_en = 0; cyc();
        @(negedge clk);
        chk("R6 req", 32'(tx_req), 1); chk("R6 len", 32'(tx_len), 60);
        chk("R6 ptr", tx_ptr, 32'h2000); chk("R6 crc", 32'(tx_crc), 1); chk("R6 last", 32'(tx_last), 1);
        tx_sent = 1; cyc(); tx_sent = 0;
        @(negedge clk); chk("R7 req drops", 32'(tx_req), 0); chk("R9 tx_done", 32'(tx_done), 1);
        cyc(); @(negedge clk);
        chk("R6 second req", 32'(tx_req), 1); chk("R6 second len", 32'(tx_len), 70);
        chk("R6 second crc", 32'(tx_crc), 0);
        tx_sent = 1; cyc(); tx_sent = 0; cyc(); cyc();
        hw(0, 2, 16'h8400, 80, 32'h2200);
        cyc(); cyc(); @(negedge clk); chk("R8 stays stopped", 32'(tx_req), 0);
        hr(0, 0); chk("R7 ready cleared", 32'(host_rstatus), 32'h0C00); chk("R7 len kept", 32'(host_rlen), 60);
        tx_sent = 1; cyc(); tx_sent = 0;
        hr(0, 2); chk("R7 idle sent ignored", 32'(host_rstatus), 32'h8400);

        // Stop while a frame is in flight.
        hw(0, 3, 16'h8000, 90, 32'h2300);
        tx_task_en = 1; cyc(); tx_task_en = 0; cyc();
        tx_stop = 1; cyc(); tx_stop = 0;
        @(negedge clk); chk("R11 frame continues", 32'(tx_req), 1);
        tx_sent = 1; cyc(); tx_sent = 0; cyc(); cyc();
        @(negedge clk); chk("R11 no further start", 32'(tx_req), 0);
        hr(0, 2); chk("R11 written back", 32'(host_rstatus), 32'h0400);
        rx_stop = 1; rx_task_en = 1; cyc(); rx_stop = 0; rx_task_en = 0;
        @(negedge clk); chk("R11 stop beats enable", 32'(rx_ready), 0);

        // Sticky events.
        @(negedge clk); chk("R10 both set", 32'(evt), 3);
        evt_clr = 2'b11; cyc(); evt_clr = 0;
        @(negedge clk); chk("R10 cleared", 32'(evt), 0);

        // Collision: write-back beats host write on the same receive slot.
        hw(1, 1, 16'hA000, 0, 32'h1100);
        rx_task_en = 1; cyc(); rx_task_en = 0;
        rx_frame_valid = 1; rx_frame_len = 33;
        host_we = 1; host_sel = 1; host_idx = 1; host_wstatus = 16'h8000; host_wlen = 5;
        cyc(); rx_frame_valid = 0; host_we = 0;
        hr(1, 1); chk("R12 walker wins status", 32'(host_rstatus), 32'h2800);
        chk("R12 walker wins len", 32'(host_rlen), 33);

        cyc(); cyc();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule